// File: doc/BRIEF.md
# Indirect Gather Copy Engine

This block copies a run of elements through a lookup table. For element k it reads an index from an index memory at address `rd_base + k`. It then reads a lookup memory at that index and stores the value it gets into a destination memory at address `wr_base + k`. All three memories sit outside the block. They are single-cycle synchronous RAMs: a read issued in one cycle returns its data in the next cycle.

Work is split into three stages: index read, lookup read and destination write. These stages overlap. While element k is written, the lookup of element k+1 and the index fetch of element k+2 go on in the same cycle. Writing the previous result and fetching the next index share one cycle, because neither needs the other. A short start-up phase issues the first index alone. A steady phase then runs count minus one times. A drain phase finishes the last lookup and write. The result is one element finished per cycle, and no cycle is lost to a data hazard.

Software starts the engine with a one-cycle `start` pulse that carries an element count and two base pointers. It then waits for the one-cycle `done` pulse.

Top module: `gather_copy_engine`

## Requirements
- R1: While and after synchronous reset, with no start, `busy`, `done`, `idx_rd_en`, `lut_rd_en` and `dst_wr_en` are all 0.
- R2: For element k (0 ≤ k < count), the value written is the lookup memory content at the address held in index memory word `rd_base + k`. It is written at destination address `wr_base + k`.
- R3: Index read addresses post-increment by one from `rd_base` on consecutive cycles. Destination write addresses post-increment by one from `wr_base` on consecutive cycles.
- R4: Take cycle 0 as the cycle after the clock edge that accepts `start`, with count C ≥ 1. Index reads are issued in cycles 0..C-1, lookup reads in cycles 1..C, and writes in cycles 2..C+1. This gives one element per cycle.
- R5: The lookup read of element k is issued exactly one cycle after its index read, using the returned index data, never earlier.
- R6: `done` is high for exactly one cycle, at cycle C+2, right after the final write. `busy` is high from cycle 0 through the `done` cycle.
- R7: A `start` pulse while `busy` is high changes nothing: not the addresses, the data, the write count nor the `done` timing. The `count`, `rd_base` and `wr_base` inputs are taken only when `start` is accepted.
- R8: A count of 0 raises `done` (and `busy`) in cycle 0 only, with no memory read or write.
- R9: The default count width carries a transfer of 256 elements, the default length.
- R10: Pointers wrap modulo the memory size: index address 255 is followed by 0, and destination address 255 is followed by 0.
- R11: Exactly C writes happen per transfer, and none while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a transfer |
| count | input | CNT_W (9) | Number of elements to copy |
| rd_base | input | IDX_AW (8) | First index memory address |
| wr_base | input | DST_AW (8) | First destination address |
| busy | output | 1 | Transfer in progress, through the done cycle |
| done | output | 1 | One-cycle completion pulse |
| idx_rd_en | output | 1 | Index memory read enable |
| idx_rd_addr | output | IDX_AW (8) | Index memory read address |
| idx_rd_data | input | LUT_AW (8) | Index memory read data, one cycle after the read |
| lut_rd_en | output | 1 | Lookup memory read enable |
| lut_rd_addr | output | LUT_AW (8) | Lookup memory read address |
| lut_rd_data | input | DATA_W (16) | Lookup memory read data, one cycle after the read |
| dst_wr_en | output | 1 | Destination write enable |
| dst_wr_addr | output | DST_AW (8) | Destination write address |
| dst_wr_data | output | DATA_W (16) | Destination write data |

## Verification
Each transfer is compared cycle by cycle against a behavioural model. The transfers use several index patterns:
- An identity index table, which exposes an engine that bypasses the lookup.
- A scrambled table, which exposes off-by-one pairing between the index and the lookup stages.
- Bases near the top of the address space, which exercise wrap-around.

Lengths of 0, 1, 2 and 256 separate the prologue-only, drain-only and steady-state paths. A run with `start` pulses mid-transfer and in the done cycle, carrying other counts and bases, shows that a busy engine ignores new requests.

// File: rtl/gather_pkg.sv
package gather_pkg;

    // Phases of one transfer
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRO,
        PH_LOOP,
        PH_EPI,
        PH_DONE
    } phase_e;

    // Stages after the index fetch: lookup read, then destination write
    localparam int DRAIN_CYCLES = 2;
    localparam int DRN_W        = $clog2(DRAIN_CYCLES);

    // Valid flags that travel behind each issued index read
    typedef struct packed {
        logic lut;
        logic wr;
    } pipe_valid_t;

    function automatic logic phase_issues(input phase_e p);
        return (p == PH_PRO) || (p == PH_LOOP);
    endfunction

    function automatic logic phase_busy(input phase_e p);
        return p != PH_IDLE;
    endfunction

endpackage

// File: rtl/gather_seq.sv
module gather_seq
    import gather_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] count,
    output logic             accept,
    output logic             issue,
    output logic             busy,
    output logic             done
);

    phase_e           ph, ph_n;
    logic [CNT_W-1:0] rem, rem_n;
    logic [DRN_W-1:0] drn, drn_n;

    assign accept = (ph == PH_IDLE) && start;
    assign issue  = phase_issues(ph);
    assign busy   = phase_busy(ph);
    assign done   = (ph == PH_DONE);

    always_comb begin
        ph_n  = ph;
        rem_n = rem;
        drn_n = drn;
        case (ph)
            PH_IDLE: begin
                if (start) begin
                    if (count == '0) begin
                        ph_n = PH_DONE;
                    end else begin
                        ph_n  = PH_PRO;
                        rem_n = count - 1'b1;
                    end
                end
            end
            PH_PRO: begin
                if (rem == '0) begin
                    ph_n  = PH_EPI;
                    drn_n = '0;
                end else begin
                    ph_n = PH_LOOP;
                end
            end
            PH_LOOP: begin
                rem_n = rem - 1'b1;
                if (rem == CNT_W'(1)) begin
                    ph_n  = PH_EPI;
                    drn_n = '0;
                end
            end
            PH_EPI: begin
                if (drn == DRN_W'(DRAIN_CYCLES - 1)) begin
                    ph_n = PH_DONE;
                end else begin
                    drn_n = drn + 1'b1;
                end
            end
            PH_DONE: ph_n = PH_IDLE;
            default: ph_n = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= PH_IDLE;
            rem <= '0;
            drn <= '0;
        end else begin
            ph  <= ph_n;
            rem <= rem_n;
            drn <= drn_n;
        end
    end

    // R6: completion is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: an empty transfer finishes in the next cycle
    p_zero_done_r8: assert property (@(posedge clk) disable iff (rst)
        (accept && count == '0) |=> done);

    // R7: a request while busy neither aborts nor restarts the run
    p_busy_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

endmodule

// File: rtl/gather_ptr.sv
module gather_ptr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] base,
    input  logic         step,
    output logic [W-1:0] ptr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= base;
        end else if (step) begin
            ptr <= ptr + 1'b1;
        end
    end

endmodule

// File: rtl/gather_pipe.sv
module gather_pipe
    import gather_pkg::*;
#(
    parameter int LUT_AW = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  logic [LUT_AW-1:0] idx_data,
    input  logic [DATA_W-1:0] lut_data,
    output logic              lut_en,
    output logic [LUT_AW-1:0] lut_addr,
    output logic              wr_fire,
    output logic [DATA_W-1:0] wr_data
);

    pipe_valid_t v;

    always_ff @(posedge clk) begin
        if (rst) begin
            v <= '0;
        end else begin
            v.lut <= issue;
            v.wr  <= v.lut;
        end
    end

    // The index word is valid only in the cycle after its read
    assign lut_en   = v.lut;
    assign lut_addr = v.lut ? idx_data : '0;
    assign wr_fire  = v.wr;
    assign wr_data  = v.wr ? lut_data : '0;

endmodule

// File: rtl/gather_copy_engine.sv
module gather_copy_engine
    import gather_pkg::*;
#(
    parameter int IDX_AW = 8,
    parameter int LUT_AW = 8,
    parameter int DST_AW = 8,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  count,
    input  logic [IDX_AW-1:0] rd_base,
    input  logic [DST_AW-1:0] wr_base,
    output logic              busy,
    output logic              done,
    output logic              idx_rd_en,
    output logic [IDX_AW-1:0] idx_rd_addr,
    input  logic [LUT_AW-1:0] idx_rd_data,
    output logic              lut_rd_en,
    output logic [LUT_AW-1:0] lut_rd_addr,
    input  logic [DATA_W-1:0] lut_rd_data,
    output logic              dst_wr_en,
    output logic [DST_AW-1:0] dst_wr_addr,
    output logic [DATA_W-1:0] dst_wr_data
);

    logic accept;
    logic issue;

    gather_seq #(.CNT_W(CNT_W)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .count  (count),
        .accept (accept),
        .issue  (issue),
        .busy   (busy),
        .done   (done)
    );

    gather_ptr #(.W(IDX_AW)) u_rptr (
        .clk  (clk),
        .rst  (rst),
        .load (accept),
        .base (rd_base),
        .step (issue),
        .ptr  (idx_rd_addr)
    );

    gather_ptr #(.W(DST_AW)) u_wptr (
        .clk  (clk),
        .rst  (rst),
        .load (accept),
        .base (wr_base),
        .step (dst_wr_en),
        .ptr  (dst_wr_addr)
    );

    gather_pipe #(.LUT_AW(LUT_AW), .DATA_W(DATA_W)) u_pipe (
        .clk      (clk),
        .rst      (rst),
        .issue    (issue),
        .idx_data (idx_rd_data),
        .lut_data (lut_rd_data),
        .lut_en   (lut_rd_en),
        .lut_addr (lut_rd_addr),
        .wr_fire  (dst_wr_en),
        .wr_data  (dst_wr_data)
    );

    assign idx_rd_en = issue;

    // R5: a lookup uses index data one cycle after its read
    p_lut_follows_idx_r5: assert property (@(posedge clk) disable iff (rst)
        lut_rd_en |-> $past(idx_rd_en));

    // R4: a write follows its lookup read by one cycle
    p_wr_follows_lut_r4: assert property (@(posedge clk) disable iff (rst)
        dst_wr_en |-> $past(lut_rd_en));

    // R3: consecutive index reads step the address by one
    p_idx_step_r3: assert property (@(posedge clk) disable iff (rst)
        (idx_rd_en && $past(idx_rd_en)) |-> (idx_rd_addr == $past(idx_rd_addr) + 1'b1));

    // R3: consecutive writes step the address by one
    p_wr_step_r3: assert property (@(posedge clk) disable iff (rst)
        (dst_wr_en && $past(dst_wr_en)) |-> (dst_wr_addr == $past(dst_wr_addr) + 1'b1));

    // R11: no write outside a transfer
    p_no_idle_write_r11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !dst_wr_en);

    // R6: done follows the final write or an empty request
    p_done_after_work_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(dst_wr_en) || $past(accept && count == '0)));

endmodule

// File: tb/tb_gather_copy_engine.sv
module tb_gather_copy_engine;

    localparam int IDX_AW = 8;
    localparam int LUT_AW = 8;
    localparam int DST_AW = 8;
    localparam int DATA_W = 16;
    localparam int CNT_W  = 9;
    localparam int IDXN   = 1 << IDX_AW;
    localparam int LUTN   = 1 << LUT_AW;
    localparam int DSTN   = 1 << DST_AW;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [CNT_W-1:0]  count = '0;
    logic [IDX_AW-1:0] rd_base = '0;
    logic [DST_AW-1:0] wr_base = '0;
    logic              busy, done;
    logic              idx_rd_en, lut_rd_en, dst_wr_en;
    logic [IDX_AW-1:0] idx_rd_addr;
    logic [LUT_AW-1:0] idx_rd_data, lut_rd_addr;
    logic [DATA_W-1:0] lut_rd_data, dst_wr_data;
    logic [DST_AW-1:0] dst_wr_addr;

    int checks = 0;
    int errors = 0;
    int wr_seen = 0;

    logic [LUT_AW-1:0] idx_mem [IDXN];
    logic [DATA_W-1:0] lut_mem [LUTN];
    logic [DATA_W-1:0] dst_mem [DSTN];

    always #4 clk = ~clk;

    gather_copy_engine #(
        .IDX_AW(IDX_AW), .LUT_AW(LUT_AW), .DST_AW(DST_AW),
        .DATA_W(DATA_W), .CNT_W(CNT_W)
    ) dut (
        .clk(clk), .rst(rst), .start(start), .count(count),
        .rd_base(rd_base), .wr_base(wr_base), .busy(busy), .done(done),
        .idx_rd_en(idx_rd_en), .idx_rd_addr(idx_rd_addr), .idx_rd_data(idx_rd_data),
        .lut_rd_en(lut_rd_en), .lut_rd_addr(lut_rd_addr), .lut_rd_data(lut_rd_data),
        .dst_wr_en(dst_wr_en), .dst_wr_addr(dst_wr_addr), .dst_wr_data(dst_wr_data)
    );

    // Behavioural single-cycle synchronous memories
    always_ff @(posedge clk) begin
        if (idx_rd_en) idx_rd_data <= idx_mem[idx_rd_addr];
        if (lut_rd_en) lut_rd_data <= lut_mem[lut_rd_addr];
        if (dst_wr_en) begin
            dst_mem[dst_wr_addr] <= dst_wr_data;
            wr_seen <= wr_seen + 1;
        end
    end

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic int ref_idx(input int a);
        return int'(idx_mem[a % IDXN]);
    endfunction

    // One transfer, compared against the model every cycle.
    // inj_a / inj_b: cycles at which a stray start is driven (-1 = none).
    task automatic run(input int c, input int rb, input int wb, input int inj_a, input int inj_b);
        int done_cyc;
        done_cyc = (c == 0) ? 0 : c + 2;
        for (int i = 0; i < DSTN; i++) dst_mem[i] = 16'hDEAD;
        wr_seen = 0;
        count   = CNT_W'(c);
        rd_base = IDX_AW'(rb);
        wr_base = DST_AW'(wb);
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        for (int cyc = 0; cyc <= done_cyc + 2; cyc++) begin
            logic ie, le, we;
            ie = (c > 0) && (cyc < c);
            le = (c > 0) && (cyc >= 1) && (cyc <= c);
            we = (c > 0) && (cyc >= 2) && (cyc <= c + 1);
            chk(c == 0 ? "R8" : "R4", "idx_rd_en", idx_rd_en, ie);
            chk(c == 0 ? "R8" : "R5", "lut_rd_en", lut_rd_en, le);
            chk(c == 0 ? "R8" : "R11", "dst_wr_en", dst_wr_en, we);
            chk("R6", "done", done, cyc == done_cyc);
            chk("R6", "busy", busy, cyc <= done_cyc);
            if (ie) chk("R3", "idx_rd_addr", idx_rd_addr, (rb + cyc) % IDXN);
            if (le) chk("R5", "lut_rd_addr", lut_rd_addr, ref_idx(rb + cyc - 1));
            if (we) begin
                chk("R10", "dst_wr_addr", dst_wr_addr, (wb + cyc - 2) % DSTN);
                chk("R2", "dst_wr_data", dst_wr_data, lut_mem[ref_idx(rb + cyc - 2)]);
            end
            if (cyc == inj_a || cyc == inj_b) begin
                // R7: stray request with other parameters
                start   = 1'b1;
                count   = CNT_W'(3);
                rd_base = IDX_AW'(rb + 77);
                wr_base = DST_AW'(wb + 33);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk("R11", "write count", wr_seen, c);
        for (int k = 0; k < c; k++)
            chk("R2", "dst contents", dst_mem[(wb + k) % DSTN], lut_mem[ref_idx(rb + k)]);
    endtask

    initial begin
        for (int i = 0; i < LUTN; i++) lut_mem[i] = DATA_W'((i * 40503 + 17) ^ (i << 5));
        for (int i = 0; i < IDXN; i++) idx_mem[i] = LUT_AW'(i);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "busy in reset", busy, 0);
        chk("R1", "done in reset", done, 0);
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1", "busy idle", busy, 0);
        chk("R1", "done idle", done, 0);
        chk("R1", "idx_rd_en idle", idx_rd_en, 0);
        chk("R1", "lut_rd_en idle", lut_rd_en, 0);
        chk("R1", "dst_wr_en idle", dst_wr_en, 0);

        // Identity table
        run(8, 0, 0, -1, -1);
        // Scrambled table, offset bases
        for (int i = 0; i < IDXN; i++) idx_mem[i] = LUT_AW'((i * 37 + 5) % LUTN);
        run(16, 10, 100, -1, -1);
        // Shortest non-empty transfers
        run(1, 40, 7, -1, -1);
        run(2, 41, 9, -1, -1);
        // R8: empty transfer, stray start in its done cycle
        run(0, 3, 3, 0, -1);
        // R10 wrap plus R7 stray starts mid-run and in done cycle
        run(20, 250, 245, 3, 22);
        // R9: default full-length transfer, reversed table
        for (int i = 0; i < IDXN; i++) idx_mem[i] = LUT_AW'(LUTN - 1 - i);
        run(256, 0, 0, -1, -1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule